// File: doc/BRIEF.md
# Prefix Fallback Table Builder

This block fills the fallback table that a linear-time string matcher consults after a mismatch. A host first loads a null-terminated pattern into a small byte RAM and then pulses `start`. The builder walks the pattern through its own read port, keeps the current write index and the current candidate index in registers, and writes one byte per pattern position into a second RAM. When it is finished it pulses `done`, and the matcher can use the table.

Both memories are single-port and synchronous, with one cycle of read latency. The pattern RAM is only read. The table RAM is written for each entry, and it is read back whenever the candidate index has to fall back to an earlier entry. The value minus one is stored as the all-ones byte 0xFF.

Top module: `prefix_table_builder`

## Requirements
- R1: Every accepted start writes table entry 0 as 0xFF (minus one) and entry 1 as 0x00, including for an empty pattern and a one-byte pattern.
- R2: The pattern length is the index of the first 0x00 byte in pattern memory. Table entries at indices at or above max(length, 2) are never written.
- R3: With write index i starting at 2 and candidate j starting at 0: when pattern[i-1] equals pattern[j], entry i is written with j+1, and then both i and j advance by one.
- R4: When pattern[i-1] differs from pattern[j] and j > 0, j takes the value held in table entry j, nothing is written, and the same i is compared again.
- R5: When pattern[i-1] differs from pattern[j] and j = 0, entry i is written with 0x00 and i advances.
- R6: For the pattern "ABCDABD" the table reads FF, 00, 00, 00, 00, 01, 02.
- R7: `busy` rises in the cycle after an accepted start and stays high until the build ends. `done` is high for exactly one cycle, and that is the cycle in which `busy` falls.
- R8: A start pulse received while `busy` is high is ignored. The run in progress completes with a single `done` pulse and a correct table.
- R9: `tbl_we` is asserted only while `busy` is high.
- R10: Patterns up to 255 bytes are supported. If none of the first 255 bytes is 0x00, the length is taken as 255 and entry 255 is not written.
- R11: After reset, `busy`, `done` and `tbl_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to build the table |
| pat_addr | output | 8 | Pattern RAM read address |
| pat_rdata | input | 8 | Pattern RAM read data, one cycle after the address |
| tbl_addr | output | 8 | Table RAM address, shared by reads and writes |
| tbl_we | output | 1 | Table RAM write enable |
| tbl_wdata | output | 8 | Table RAM write data |
| tbl_rdata | input | 8 | Table RAM read data, one cycle after the address |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle pulse when the build ends |

## Verification
The bench builds the block with its default 8-bit index width. At that width it can reach the full 255-byte pattern, including the case where no terminator appears inside the first 255 bytes, and it can check that entry 255 is left alone. A short two-letter alphabet and runs of repeated letters force chains of fallbacks several levels deep. Empty and one-byte patterns exercise the fixed first two entries with no loop at all.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    localparam int PTB_AW   = 8;
    localparam int PTB_DW   = 8;
    localparam int PTB_MAXI = (1 << PTB_AW) - 1;

    typedef logic [PTB_AW-1:0] idx_t;
    typedef logic [PTB_DW-1:0] byte_t;

    localparam byte_t PTB_NEG_ONE = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD0,
        ST_HEAD1,
        ST_HEAD2,
        ST_CHKI,
        ST_CMP,
        ST_FBK
    } ptb_state_e;

    typedef enum logic [1:0] {
        TOP_NONE,
        TOP_WRITE,
        TOP_READ
    } tbl_op_e;

    typedef struct packed {
        tbl_op_e op;
        idx_t    addr;
        byte_t   data;
    } tbl_cmd_t;

    function automatic tbl_cmd_t tbl_write(idx_t a, byte_t d);
        tbl_cmd_t c;
        c.op   = TOP_WRITE;
        c.addr = a;
        c.data = d;
        return c;
    endfunction

    function automatic tbl_cmd_t tbl_read(idx_t a);
        tbl_cmd_t c;
        c.op   = TOP_READ;
        c.addr = a;
        c.data = '0;
        return c;
    endfunction

endpackage

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
    import ptb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  byte_t    pat_rdata,
    input  byte_t    tbl_rdata,
    output idx_t     pat_addr,
    output tbl_cmd_t tcmd,
    output logic     busy,
    output logic     done
);

    ptb_state_e state_q, state_d;
    idx_t       i_q, i_d, j_q, j_d;
    byte_t      prev_q, prev_d, cur_q, cur_d;
    logic       empty_q, empty_d;
    logic       done_q, done_d;

    always_comb begin
        state_d  = state_q;
        i_d      = i_q;
        j_d      = j_q;
        prev_d   = prev_q;
        cur_d    = cur_q;
        empty_d  = empty_q;
        done_d   = 1'b0;
        pat_addr = '0;
        tcmd     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_HEAD0;
            end
            ST_HEAD0: begin
                pat_addr = idx_t'(0);
                tcmd     = tbl_write(idx_t'(0), PTB_NEG_ONE);
                state_d  = ST_HEAD1;
            end
            ST_HEAD1: begin
                pat_addr = idx_t'(1);
                tcmd     = tbl_write(idx_t'(1), '0);
                empty_d  = (pat_rdata == '0);
                state_d  = ST_HEAD2;
            end
            ST_HEAD2: begin
                if (empty_q || pat_rdata == '0) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    prev_d   = pat_rdata;
                    i_d      = idx_t'(2);
                    j_d      = '0;
                    pat_addr = idx_t'(2);
                    state_d  = ST_CHKI;
                end
            end
            ST_CHKI: begin
                if (pat_rdata == '0 || i_q == idx_t'(PTB_MAXI)) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cur_d    = pat_rdata;
                    pat_addr = j_q;
                    state_d  = ST_CMP;
                end
            end
            ST_CMP: begin
                if (prev_q == pat_rdata) begin
                    tcmd     = tbl_write(i_q, byte_t'(j_q + 1'b1));
                    i_d      = i_q + 1'b1;
                    j_d      = j_q + 1'b1;
                    prev_d   = cur_q;
                    pat_addr = i_q + 1'b1;
                    state_d  = ST_CHKI;
                end else if (j_q != '0) begin
                    tcmd    = tbl_read(j_q);
                    state_d = ST_FBK;
                end else begin
                    tcmd     = tbl_write(i_q, '0);
                    i_d      = i_q + 1'b1;
                    prev_d   = cur_q;
                    pat_addr = i_q + 1'b1;
                    state_d  = ST_CHKI;
                end
            end
            ST_FBK: begin
                j_d      = idx_t'(tbl_rdata);
                pat_addr = idx_t'(tbl_rdata);
                state_d  = ST_CMP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            i_q     <= '0;
            j_q     <= '0;
            prev_q  <= '0;
            cur_q   <= '0;
            empty_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            i_q     <= i_d;
            j_q     <= j_d;
            prev_q  <= prev_d;
            cur_q   <= cur_d;
            empty_q <= empty_d;
            done_q  <= done_d;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    // candidate stays behind the write index inside the loop (R4)
    p_cand_below_idx_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CMP || state_q == ST_FBK) |-> (j_q < i_q && i_q >= idx_t'(2)));

    // a fallback read is always followed by a compare with the same i (R4)
    p_fbk_keeps_i_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FBK) |=> (state_q == ST_CMP && $stable(i_q)));

    // start while busy does not restart the header sequence (R8)
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state_q != ST_HEAD2 && state_q != ST_CHKI) |=> (state_q != ST_HEAD0));

endmodule

// File: rtl/ptb_memif.sv
module ptb_memif
    import ptb_pkg::*;
(
    input  tbl_cmd_t tcmd,
    output idx_t     tbl_addr,
    output logic     tbl_we,
    output byte_t    tbl_wdata
);

    assign tbl_addr  = tcmd.addr;
    assign tbl_we    = (tcmd.op == TOP_WRITE);
    assign tbl_wdata = tcmd.data;

endmodule

// File: rtl/prefix_table_builder.sv
module prefix_table_builder
    import ptb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic [7:0] pat_addr,
    input  logic [7:0] pat_rdata,
    output logic [7:0] tbl_addr,
    output logic       tbl_we,
    output logic [7:0] tbl_wdata,
    input  logic [7:0] tbl_rdata,
    output logic       busy,
    output logic       done
);

    tbl_cmd_t tcmd;

    ptb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pat_rdata (pat_rdata),
        .tbl_rdata (tbl_rdata),
        .pat_addr  (pat_addr),
        .tcmd      (tcmd),
        .busy      (busy),
        .done      (done)
    );

    ptb_memif u_memif (
        .tcmd      (tcmd),
        .tbl_addr  (tbl_addr),
        .tbl_we    (tbl_we),
        .tbl_wdata (tbl_wdata)
    );

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_busy_rise_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_write_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> busy);

    p_first_entry_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (tbl_we && tbl_addr == 8'd0 && tbl_wdata == 8'hFF));

    p_second_entry_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> (tbl_we && tbl_addr == 8'd1 && tbl_wdata == 8'h00));

endmodule

// File: tb/prefix_table_builder_tb.sv
module prefix_table_builder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] pat_addr, pat_rdata, tbl_addr, tbl_wdata, tbl_rdata;
    logic       tbl_we, busy, done;

    logic [7:0] pat_mem [256];
    logic [7:0] tbl_mem [256];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int done_cnt = 0;
    bit prev_busy = 1'b0;
    bit prev_done = 1'b0;
    bit prev_start = 1'b0;

    always #4 clk = ~clk;

    prefix_table_builder u_dut (
        .clk(clk), .rst(rst), .start(start),
        .pat_addr(pat_addr), .pat_rdata(pat_rdata),
        .tbl_addr(tbl_addr), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
        .tbl_rdata(tbl_rdata), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        pat_rdata <= pat_mem[pat_addr];
        tbl_rdata <= tbl_mem[tbl_addr];
        if (tbl_we) tbl_mem[tbl_addr] <= tbl_wdata;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // protocol monitor, sampled away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R7: watchdog expired actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (!rst) begin
            if (done) begin
                done_cnt++;
                check(prev_busy && !busy, "R7 busy falls with done", int'(busy), 0);
                check(!prev_done, "R7 done one cycle", int'(prev_done), 0);
            end
            if (busy && !prev_busy) check(prev_start, "R7 busy after start", int'(prev_start), 1);
            if (tbl_we && !busy) check(1'b0, "R9 write while idle", 1, 0);
        end
        prev_busy  = busy;
        prev_done  = done;
        prev_start = start;
    end

    function automatic int ref_len();
        for (int k = 0; k < 255; k++) if (pat_mem[k] == 8'h00) return k;
        return 255;
    endfunction

    task automatic ref_table(output int t[256], output int n);
        int i, j;
        n = ref_len();
        for (int k = 0; k < 256; k++) t[k] = 'hA5;
        t[0] = 'hFF;
        t[1] = 0;
        i = 2;
        j = 0;
        while (i < n) begin
            if (pat_mem[i-1] == pat_mem[j]) begin
                t[i] = j + 1; i++; j++;
            end else if (j > 0) begin
                j = t[j];
            end else begin
                t[i] = 0; i++;
            end
        end
    endtask

    task automatic set_str(string s);
        for (int k = 0; k < 256; k++) pat_mem[k] = 8'h00;
        for (int k = 0; k < s.len(); k++) pat_mem[k] = s[k];
    endtask

    task automatic build(int poke_at);
        int w;
        for (int k = 0; k < 256; k++) tbl_mem[k] = 8'hA5;
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        w = 0;
        while (!done && w < 5000) begin
            if (w == poke_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            w++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(string tag);
        int t[256];
        int n, lim;
        ref_table(t, n);
        lim = (n < 2) ? 2 : n;
        check(done_cnt == 1, "R7 one done per run", done_cnt, 1);
        for (int k = 0; k < 256; k++) begin
            if (k < 2)
                check(int'(tbl_mem[k]) == t[k], "R1", int'(tbl_mem[k]), t[k]);
            else if (k < lim)
                check(int'(tbl_mem[k]) == t[k], tag, int'(tbl_mem[k]), t[k]);
            else
                check(tbl_mem[k] == 8'hA5, "R2 untouched tail", int'(tbl_mem[k]), 'hA5);
        end
    endtask

    initial begin
        for (int k = 0; k < 256; k++) begin pat_mem[k] = 8'h00; tbl_mem[k] = 8'h00; end
        repeat (3) @(negedge clk);
        check(!busy && !done && !tbl_we, "R11 reset outputs", int'({busy, done, tbl_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R11 idle after reset", int'({busy, done}), 0);

        set_str("");         build(-1); verify("R1");
        set_str("A");        build(-1); verify("R2");
        set_str("ABCDABD");  build(-1); verify("R6");
        check(tbl_mem[5] == 8'h01 && tbl_mem[6] == 8'h02, "R6 tail entries",
              int'({tbl_mem[5], tbl_mem[6]}), 'h0102);
        set_str("AAAA");     build(-1); verify("R3");
        set_str("ABCD");     build(-1); verify("R5");
        set_str("AABAAAB");  build(-1); verify("R4");
        set_str("ABABAB");   build(-1); verify("R4");
        set_str("AAAAB");    build(-1); verify("R4");

        for (int r = 0; r < 12; r++) begin
            int n;
            n = 3 + ($urandom % 40);
            for (int k = 0; k < 256; k++) pat_mem[k] = 8'h00;
            for (int k = 0; k < n; k++) pat_mem[k] = (r < 8) ? 8'h41 + 8'($urandom % 2)
                                                              : 8'h41 + 8'($urandom % 4);
            build(-1); verify("R3");
        end

        for (int k = 0; k < 256; k++) pat_mem[k] = (k < 255) ? 8'h41 : 8'h00;
        build(-1); verify("R10");
        for (int k = 0; k < 256; k++) pat_mem[k] = (k < 255) ? 8'h41 + 8'($urandom % 2) : 8'h00;
        build(-1); verify("R10");
        for (int k = 0; k < 256; k++) pat_mem[k] = 8'h42;
        build(-1); verify("R10");
        check(tbl_mem[255] == 8'hA5, "R10 entry 255 unwritten", int'(tbl_mem[255]), 'hA5);

        set_str("ABCDABD");  build(4);  verify("R8");
        set_str("AABAAAB");  build(9);  verify("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule